// File: doc/BRIEF.md
# MAC Product Conditioner

This block sits in front of a 48-bit multiply-accumulate datapath. It multiplies two 32-bit operands and conditions the 64-bit product before it reaches the accumulate adder. There are three arithmetic modes: signed integer, unsigned integer and signed fractional. In the integer modes the unit checks whether the product fits a 40-bit range. When it does not, the unit either truncates the product to that range or replaces it with a sentinel. The sentinel is chosen so that the later accumulation is certain to overflow. In fractional mode the product is scaled down by 24 bits, and it can be rounded to the nearest even value.

The unit is a two-stage pipeline. The first stage is the multiplier. The second stage is the conditioner. Each stage is tracked by a small slot state machine with the states SLOT_EMPTY and SLOT_FULL. A slot takes the transition LOAD when new data arrives and DRAIN when none arrives. A sticky overflow indicator is kept by a second state machine with the states STK_CLEAR and STK_SET. It takes the transition RAISE when an overflowing result leaves the pipeline, and the transition WIPE when software clears it while no new overflow arrives in the same cycle. The indicator also returns to STK_CLEAR on reset.

Top module: `mac_prod_cond`

## Requirements
- R1: A result is presented with `out_valid` high exactly two clock edges after `in_valid` is sampled high. Back-to-back inputs give back-to-back results. `out_valid` is low in every cycle that has no corresponding input.
- R2: Mode `2'b00` (signed integer) forms the two's-complement product. When the product lies in [-2^39, 2^39-1], it is output unchanged and no overflow is flagged. `round_en` has no effect in this mode.
- R3: A signed product outside that range is an overflow. With `sat_en` low, the output is the low 40 bits of the product sign-extended to 64 bits.
- R4: On a signed overflow with `sat_en` high, the output is 2^50 (64'h0004_0000_0000_0000) for a positive product and its bitwise complement (64'hFFFB_FFFF_FFFF_FFFF) for a negative product.
- R5: Mode `2'b01` (unsigned integer) forms the unsigned product. A product below 2^40 is output unchanged with no overflow. `round_en` has no effect in this mode.
- R6: An unsigned product with any of bits 63..40 set is an overflow. The output is 2^50 when `sat_en` is high, and otherwise the product's low 40 bits zero-extended.
- R7: Mode `2'b10` (fractional) forms the signed product and shifts it arithmetically right by 24. With `round_en` low the shifted value is output as is. This mode never flags overflow.
- R8: In fractional mode with `round_en` high, the discarded 24-bit remainder decides the rounding. A remainder above 24'h800000 adds one. A remainder equal to 24'h800000 adds one only when the shifted value is odd. A smaller remainder adds nothing.
- R9: `v_flag` rises at the same clock edge as an overflowing result appears on `prod_out`, and it stays high afterwards.
- R10: `v_flag` clears at the clock edge that samples `clr_v` high. If an overflowing result is captured at that same edge, the set wins and `v_flag` stays high.
- R11: Mode `2'b11` behaves exactly like mode `2'b00`.
- R12: While `rst_n` is low, `out_valid` and `v_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First multiplier operand |
| op_b | input | 32 | Second multiplier operand |
| mode | input | 2 | 00 signed, 01 unsigned, 10 fractional, 11 as signed |
| sat_en | input | 1 | Overflow mode control: force sentinel on integer overflow |
| round_en | input | 1 | Round to nearest even in fractional mode |
| clr_v | input | 1 | Clear the sticky overflow indicator |
| out_valid | output | 1 | `prod_out` holds a new result |
| prod_out | output | 64 | Conditioned product |
| v_flag | output | 1 | Sticky overflow indicator |

## Verification
Each product, and its `out_valid`, is due two rising edges after the edge that samples `in_valid`. The overflow indicator changes at that same second edge. A `clr_v` takes effect at the first edge that samples it. The bench drives all inputs on the falling edge. At every falling edge it first compares the outputs against an expectation computed two falling edges earlier and held in a two-deep expectation pipeline. Only then does it drive the next stimulus. The expected indicator is folded forward using the `clr_v` value that the edge just passed actually sampled.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [1:0] {
        MD_SINT = 2'b00,
        MD_UINT = 2'b01,
        MD_FRAC = 2'b10,
        MD_RSVD = 2'b11
    } mpc_mode_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    typedef enum logic {
        STK_CLEAR = 1'b0,
        STK_SET   = 1'b1
    } sticky_e;

endpackage

// File: rtl/mpc_mul_stage.sv
module mpc_mul_stage
    import mpc_pkg::*;
#(
    parameter int OP_W       = 32,
    parameter int PROD_W     = 64,
    parameter int SHARED_MUL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  mpc_mode_e         mode,
    input  logic              sat_en,
    input  logic              round_en,
    output slot_e             slot_q,
    output logic [PROD_W-1:0] prod_q,
    output mpc_mode_e         mode_q,
    output logic              sat_q,
    output logic              rnd_q
);

    localparam int EXT_W = OP_W + 1;

    logic              signed_op;
    logic [PROD_W-1:0] prod_d;
    slot_e             slot_d;

    // Every mode except unsigned treats the operands as two's complement.
    assign signed_op = (mode != MD_UINT);

    generate
        if (SHARED_MUL != 0) begin : g_shared
            // One signed multiplier; an extra top bit selects the sign handling.
            logic signed [EXT_W-1:0] ext_a;
            logic signed [EXT_W-1:0] ext_b;
            assign ext_a  = $signed({signed_op & op_a[OP_W-1], op_a});
            assign ext_b  = $signed({signed_op & op_b[OP_W-1], op_b});
            assign prod_d = PROD_W'(ext_a * ext_b);
        end else begin : g_split
            logic [PROD_W-1:0] prod_s;
            logic [PROD_W-1:0] prod_u;
            assign prod_s = PROD_W'($signed(op_a) * $signed(op_b));
            assign prod_u = PROD_W'(op_a * op_b);
            assign prod_d = signed_op ? prod_s : prod_u;
        end
    endgenerate

    // Slot transitions: LOAD on in_valid, DRAIN otherwise.
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_EMPTY: slot_d = in_valid ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL:  slot_d = in_valid ? SLOT_FULL : SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_EMPTY;
        else        slot_q <= slot_d;
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            prod_q <= prod_d;
            mode_q <= mode;
            sat_q  <= sat_en;
            rnd_q  <= round_en;
        end
    end

endmodule

// File: rtl/mpc_condition.sv
module mpc_condition
    import mpc_pkg::*;
#(
    parameter int PROD_W   = 64,
    parameter int RANGE_W  = 40,
    parameter int FRAC_SH  = 24,
    parameter int SENT_POS = 50
) (
    input  logic [PROD_W-1:0] prod,
    input  mpc_mode_e         mode,
    input  logic              sat,
    input  logic              rnd,
    output logic [PROD_W-1:0] res,
    output logic              ovf
);

    localparam int                  HI_W     = PROD_W - RANGE_W;
    localparam logic [PROD_W-1:0]   SENTINEL = PROD_W'(1) << SENT_POS;
    localparam logic [FRAC_SH-1:0]  HALF     = FRAC_SH'(1) << (FRAC_SH - 1);

    logic [PROD_W-1:0]  sext_lo;
    logic [PROD_W-1:0]  zext_lo;
    logic               ovf_s;
    logic               ovf_u;
    logic [PROD_W-1:0]  frac_shift;
    logic [FRAC_SH-1:0] frac_rem;
    logic               frac_bump;
    logic [PROD_W-1:0]  frac_res;

    assign sext_lo = {{HI_W{prod[RANGE_W-1]}}, prod[RANGE_W-1:0]};
    assign zext_lo = {{HI_W{1'b0}}, prod[RANGE_W-1:0]};
    assign ovf_s   = (sext_lo != prod);
    assign ovf_u   = |prod[PROD_W-1:RANGE_W];

    assign frac_shift = PROD_W'($signed(prod) >>> FRAC_SH);
    assign frac_rem   = prod[FRAC_SH-1:0];
    assign frac_bump  = rnd && ((frac_rem > HALF) || ((frac_rem == HALF) && frac_shift[0]));
    assign frac_res   = frac_shift + {{(PROD_W-1){1'b0}}, frac_bump};

    always_comb begin
        res = prod;
        ovf = 1'b0;
        unique case (mode)
            MD_SINT, MD_RSVD: begin
                ovf = ovf_s;
                if (ovf_s) res = sat ? (prod[PROD_W-1] ? ~SENTINEL : SENTINEL) : sext_lo;
            end
            MD_UINT: begin
                ovf = ovf_u;
                if (ovf_u) res = sat ? SENTINEL : zext_lo;
            end
            MD_FRAC: begin
                res = frac_res;
            end
        endcase
    end

endmodule

// File: rtl/mpc_cond_stage.sv
module mpc_cond_stage
    import mpc_pkg::*;
#(
    parameter int PROD_W   = 64,
    parameter int RANGE_W  = 40,
    parameter int FRAC_SH  = 24,
    parameter int SENT_POS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             s1_slot,
    input  logic [PROD_W-1:0] s1_prod,
    input  mpc_mode_e         s1_mode,
    input  logic              s1_sat,
    input  logic              s1_rnd,
    output slot_e             slot_q,
    output logic [PROD_W-1:0] res_q,
    output logic              ovf_q,
    output mpc_mode_e         mode_q,
    output logic              sat_q,
    output logic              set_req
);

    logic [PROD_W-1:0] res_d;
    logic              ovf_d;
    slot_e             slot_d;

    mpc_condition #(
        .PROD_W  (PROD_W),
        .RANGE_W (RANGE_W),
        .FRAC_SH (FRAC_SH),
        .SENT_POS(SENT_POS)
    ) u_condition (
        .prod(s1_prod),
        .mode(s1_mode),
        .sat (s1_sat),
        .rnd (s1_rnd),
        .res (res_d),
        .ovf (ovf_d)
    );

    // Overflow request to the sticky indicator, timed with the capture below.
    assign set_req = (s1_slot == SLOT_FULL) && ovf_d;

    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_EMPTY: slot_d = (s1_slot == SLOT_FULL) ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL:  slot_d = (s1_slot == SLOT_FULL) ? SLOT_FULL : SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_EMPTY;
        else        slot_q <= slot_d;
    end

    always_ff @(posedge clk) begin
        if (s1_slot == SLOT_FULL) begin
            res_q  <= res_d;
            ovf_q  <= ovf_d;
            mode_q <= s1_mode;
            sat_q  <= s1_sat;
        end
    end

endmodule

// File: rtl/mpc_sticky.sv
module mpc_sticky
    import mpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic v_flag
);

    sticky_e state_q;
    sticky_e state_d;

    // RAISE on an overflow; WIPE on a clear with no overflow in the same cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_CLEAR: state_d = set_req ? STK_SET : STK_CLEAR;
            STK_SET:   state_d = (clr_req && !set_req) ? STK_CLEAR : STK_SET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STK_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        v_flag = (state_q == STK_SET);
    end

endmodule

// File: rtl/mac_prod_cond.sv
module mac_prod_cond
    import mpc_pkg::*;
#(
    parameter int OP_W       = 32,
    parameter int RANGE_W    = 40,
    parameter int FRAC_SH    = 24,
    parameter int SENT_POS   = 50,
    parameter int SHARED_MUL = 1,
    localparam int PROD_W    = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [1:0]        mode,
    input  logic              sat_en,
    input  logic              round_en,
    input  logic              clr_v,
    output logic              out_valid,
    output logic [PROD_W-1:0] prod_out,
    output logic              v_flag
);

    slot_e             s1_slot;
    logic [PROD_W-1:0] s1_prod;
    mpc_mode_e         s1_mode;
    logic              s1_sat;
    logic              s1_rnd;
    slot_e             s2_slot;
    logic              s2_ovf;
    mpc_mode_e         s2_mode;
    logic              s2_sat;
    logic              ovf_set;

    mpc_mul_stage #(
        .OP_W      (OP_W),
        .PROD_W    (PROD_W),
        .SHARED_MUL(SHARED_MUL)
    ) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .op_a    (op_a),
        .op_b    (op_b),
        .mode    (mpc_mode_e'(mode)),
        .sat_en  (sat_en),
        .round_en(round_en),
        .slot_q  (s1_slot),
        .prod_q  (s1_prod),
        .mode_q  (s1_mode),
        .sat_q   (s1_sat),
        .rnd_q   (s1_rnd)
    );

    mpc_cond_stage #(
        .PROD_W  (PROD_W),
        .RANGE_W (RANGE_W),
        .FRAC_SH (FRAC_SH),
        .SENT_POS(SENT_POS)
    ) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .s1_slot(s1_slot),
        .s1_prod(s1_prod),
        .s1_mode(s1_mode),
        .s1_sat (s1_sat),
        .s1_rnd (s1_rnd),
        .slot_q (s2_slot),
        .res_q  (prod_out),
        .ovf_q  (s2_ovf),
        .mode_q (s2_mode),
        .sat_q  (s2_sat),
        .set_req(ovf_set)
    );

    mpc_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(ovf_set),
        .clr_req(clr_v),
        .v_flag (v_flag)
    );

    assign out_valid = (s2_slot == SLOT_FULL);

endmodule

// File: rtl/mac_prod_cond_chk.sv
module mac_prod_cond_chk
    import mpc_pkg::*;
#(
    parameter int PROD_W  = 64,
    parameter int RANGE_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic              v_flag,
    input logic              clr_v,
    input logic              ovf_q,
    input logic [1:0]        mode_q,
    input logic              sat_q,
    input logic [PROD_W-1:0] prod_out
);

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r1_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (v_flag && !clr_v) |=> v_flag);

    a_r9_set_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_q) |-> v_flag);

    a_r10_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v_flag) |-> $past(clr_v));

    a_r3_signed_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_q && !sat_q && (mode_q == MD_SINT || mode_q == MD_RSVD))
        |-> ((prod_out[PROD_W-1:RANGE_W-1] == '0) || (prod_out[PROD_W-1:RANGE_W-1] == '1)));

    a_r6_unsigned_trunc: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_q && !sat_q && mode_q == MD_UINT)
        |-> (prod_out[PROD_W-1:RANGE_W] == '0));

    a_r7_frac_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == MD_FRAC) |-> !ovf_q);

endmodule

bind mac_prod_cond mac_prod_cond_chk #(
    .PROD_W (PROD_W),
    .RANGE_W(RANGE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .v_flag   (v_flag),
    .clr_v    (clr_v),
    .ovf_q    (s2_ovf),
    .mode_q   (s2_mode),
    .sat_q    (s2_sat),
    .prod_out (prod_out)
);

// File: tb/mac_prod_cond_tb.sv
`timescale 1ns/1ps
module mac_prod_cond_tb;

    localparam logic [63:0] SENT = 64'h0004_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic [1:0]  mode;
    logic        sat_en, round_en, clr_v;
    logic        out_valid;
    logic [63:0] prod_out;
    logic        v_flag;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    bit          e1_vld = 0, e2_vld = 0;
    logic [63:0] e1_prod = '0, e2_prod = '0;
    bit          e1_ovf = 0, e2_ovf = 0;
    string       e1_tag = "", e2_tag = "";
    bit          v_exp = 0;

    always #5 clk = ~clk;

    mac_prod_cond u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .sat_en(sat_en), .round_en(round_en), .clr_v(clr_v),
        .out_valid(out_valid), .prod_out(prod_out), .v_flag(v_flag)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] md,
                                      input bit sat, input bit rnd,
                                      output logic [63:0] r, output bit ovf, output string tag);
        longint      ps;
        logic [63:0] pu;
        longint      q;
        logic [23:0] rem;
        ps  = longint'($signed(a)) * longint'($signed(b));
        pu  = {32'h0, a} * {32'h0, b};
        ovf = 0;
        case (md)
            2'b01: begin
                ovf = (pu >= 64'h100_0000_0000);
                r   = ovf ? (sat ? SENT : {24'h0, pu[39:0]}) : pu;
                tag = ovf ? "R6" : "R5";
            end
            2'b10: begin
                q   = ps >>> 24;
                rem = ps[23:0];
                if (rnd && ((rem > 24'h800000) || ((rem == 24'h800000) && q[0]))) q = q + 1;
                r   = q;
                tag = rnd ? "R8" : "R7";
            end
            default: begin
                ovf = (ps > 64'sh7F_FFFF_FFFF) || (ps < -64'sh80_0000_0000);
                if (ovf) r = sat ? ((ps < 0) ? ~SENT : SENT) : {{24{ps[39]}}, ps[39:0]};
                else     r = ps;
                tag = ovf ? (sat ? "R4" : "R3") : "R2";
                if (md == 2'b11) tag = "R11";
            end
        endcase
    endfunction

    // One cycle: check the result due now, then drive the next stimulus.
    task automatic step(input bit vld, input logic [31:0] a, input logic [31:0] b, input logic [1:0] md,
                        input bit sat, input bit rnd, input bit clr);
        logic [63:0] r;
        bit          ovf;
        string       tag;
        @(negedge clk);
        check("R1", "out_valid", {63'h0, out_valid}, {63'h0, e2_vld});
        if (e2_vld) check(e2_tag, "prod_out", prod_out, e2_prod);
        v_exp = (v_exp && !clr_v) || (e2_vld && e2_ovf);
        check(clr_v ? "R10" : "R9", "v_flag", {63'h0, v_flag}, {63'h0, v_exp});
        e2_vld = e1_vld; e2_prod = e1_prod; e2_ovf = e1_ovf; e2_tag = e1_tag;
        ref_model(a, b, md, sat, rnd, r, ovf, tag);
        e1_vld = vld; e1_prod = r; e1_ovf = vld && ovf; e1_tag = tag;
        in_valid = vld; op_a = a; op_b = b; mode = md; sat_en = sat; round_en = rnd; clr_v = clr;
    endtask

    function automatic logic [31:0] pick_op();
        logic [31:0] v;
        case ($urandom % 4)
            0: v = $urandom;
            1: v = {{16{$urandom_range(0, 1) == 1}}, 16'($urandom)};
            2: v = (32'h1 << ($urandom % 32)) + 32'($urandom_range(0, 2)) - 32'd1;
            default: case ($urandom % 4)
                0: v = 32'h7FFF_FFFF;
                1: v = 32'h8000_0000;
                2: v = 32'hFFFF_FFFF;
                default: v = 32'h0080_0000;
            endcase
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; in_valid = 0; op_a = 0; op_b = 0; mode = 0;
        sat_en = 0; round_en = 0; clr_v = 0;
        repeat (3) @(negedge clk);
        check("R12", "out_valid in reset", {63'h0, out_valid}, 64'h0);
        check("R12", "v_flag in reset", {63'h0, v_flag}, 64'h0);
        rst_n = 1;

        // R2: in-range signed products, including the lower edge -2^39
        step(1, 32'h0001_0000, 32'hFFFF_0000, 2'b00, 1, 1, 0);
        step(1, 32'h0008_0000, 32'hFFF0_0000, 2'b00, 1, 0, 0);
        // R3/R4: exactly 2^39 overflows; saturated and truncated forms
        step(1, 32'h0008_0000, 32'h0010_0000, 2'b00, 0, 0, 0);
        step(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1, 0, 0);
        step(1, 32'h8000_0000, 32'h7FFF_FFFF, 2'b00, 1, 0, 0);
        step(1, 32'h8000_0000, 32'h7FFF_FFFF, 2'b00, 0, 0, 0);
        // R10: clear with no overflow arriving
        step(0, 0, 0, 2'b00, 0, 0, 1);
        step(0, 0, 0, 2'b00, 0, 0, 1);
        step(0, 0, 0, 2'b00, 0, 0, 0);
        step(0, 0, 0, 2'b00, 0, 0, 0);
        // R5/R6: unsigned boundary 2^40 and the all-ones product
        step(1, 32'h0010_0000, 32'h000F_FFFF, 2'b01, 1, 1, 0);
        step(1, 32'h0010_0000, 32'h0010_0000, 2'b01, 0, 0, 0);
        step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 1, 0, 0);
        step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 0, 0, 0);
        // R10: set wins over a clear at the same edge
        step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 0, 0, 0);
        step(0, 0, 0, 2'b00, 0, 0, 1);
        step(0, 0, 0, 2'b00, 0, 0, 1);
        step(0, 0, 0, 2'b00, 0, 0, 0);
        // R7/R8: rounding ties to even, above half, and truncation
        step(1, 32'h0080_0000, 32'h0000_0001, 2'b10, 0, 1, 0);
        step(1, 32'h0180_0000, 32'h0000_0001, 2'b10, 0, 1, 0);
        step(1, 32'h0080_0001, 32'h0000_0001, 2'b10, 0, 1, 0);
        step(1, 32'h0080_0001, 32'h0000_0001, 2'b10, 0, 0, 0);
        step(1, 32'hFF80_0000, 32'h0000_0001, 2'b10, 1, 1, 0);
        step(1, 32'h8000_0000, 32'h8000_0000, 2'b10, 1, 1, 0);
        // R11: reserved mode behaves as signed
        step(1, 32'h7FFF_FFFF, 32'h8000_0000, 2'b11, 1, 0, 0);
        step(1, 32'h0000_1234, 32'hFFFF_FFFE, 2'b11, 0, 1, 0);

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, pick_op(), pick_op(), 2'($urandom), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, ($urandom % 16) == 0);
        end
        repeat (3) step(0, 0, 0, 2'b00, 0, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule